// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Port

This block is the device-side logic of an 8064-byte one-time-programmable program store while the part sits in its programming mode. There are no address pins. A 4-bit mode code picks one of four operations: zero the address, program the current byte, read the current byte back, or hold (inhibit). A separate address-clock input moves an internal pointer forward by one location after every fourth rising edge. Each byte crosses the pins as two 4-bit halves, the low nibble on one port and the high nibble on the other.

An external programmer works in a fixed order. It zeroes the address, then repeats these steps for every location: apply the byte in program mode, read it back in verify mode, retry if needed, and clock the address forward four times. A single "programming supply present" input gates the whole mode. When it is low, every code is treated as inhibit. The storage is a behavioural array of one-time cells that starts blank, with every bit at one. Programming can only clear bits.

Top module: `otp_prog_port`

## Requirements
- R1: After synchronous reset the address and the address-clock edge count are zero, the output enable is low, and every stored byte reads as 8'hFF.
- R2: With `prog_hv_i` high, `mode_code_i` (bit 0 = first mode line) selects the operation: 4'b0101 clears the address, 4'b1110 programs, 4'b1100 verifies, and 4'b1101 or 4'b1111 inhibit. With `prog_hv_i` low, every code acts as inhibit.
- R3: Outside the clear operation, each fourth rising edge on `xclk_i` advances the address by exactly one. Fewer than four edges leave the address unchanged.
- R4: The clear operation sets the address and the edge count to zero. Rising edges on `xclk_i` that occur while clear is selected are not counted.
- R5: The address saturates at 8063 (13'h1F7F). Further groups of four edges leave it there.
- R6: In the program operation, the byte at the current address becomes its old value ANDed with {`data_hi_i`,`data_lo_i`}. A bit can go from 1 to 0 but never from 0 to 1.
- R7: Program code 4'b1110 with `prog_hv_i` low leaves the stored contents unchanged.
- R8: In the verify operation, `data_oe_o` is high one cycle after the code is applied. `data_lo_o` carries bits 3:0 and `data_hi_o` carries bits 7:4 of the byte at the current address, within three cycles.
- R9: In every operation other than verify, `data_oe_o` is low and both data outputs are zero.
- R10: An undefined code, for example 4'b0000, behaves as inhibit: it does not program, it does not clear, and the address still counts `xclk_i` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_hv_i | input | 1 | Programming supply present; gates every operation |
| mode_code_i | input | 4 | Operation select, bit 0 = first mode line |
| xclk_i | input | 1 | Address clock; rising edges counted synchronously |
| data_lo_i | input | 4 | Program data bits 3:0 |
| data_hi_i | input | 4 | Program data bits 7:4 |
| data_lo_o | output | 4 | Verify data bits 3:0 |
| data_hi_o | output | 4 | Verify data bits 7:4 |
| data_oe_o | output | 1 | High when the verify data is driven |

## Verification
The address is invisible at the pins, so any fault in the pointer or in the edge counter shows up as a wrong byte in the next verify read. The bench therefore gives neighbouring locations different patterns, which turns an off-by-one step into a visible data mismatch within three cycles. A program operation that sets bits, or that ignores the supply gate, shows in the following read-back of that location. A decode fault shows as the output enable being wrong one cycle after the code changes.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    localparam int NIB_W        = 4;
    localparam int BYTE_W       = 2 * NIB_W;
    localparam int DEF_DEPTH    = 8064;
    localparam int DEF_EDGES    = 4;

    // mode codes, bit 0 = first mode line
    localparam logic [3:0] CODE_CLEAR  = 4'b0101;
    localparam logic [3:0] CODE_WRITE  = 4'b1110;
    localparam logic [3:0] CODE_VERIFY = 4'b1100;

    typedef enum logic [1:0] {
        OP_INHIBIT = 2'd0,
        OP_CLEAR   = 2'd1,
        OP_WRITE   = 2'd2,
        OP_VERIFY  = 2'd3
    } prog_op_e;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } split_byte_t;

    function automatic prog_op_e decode_op(input logic [3:0] code, input logic hv);
        prog_op_e op;
        op = OP_INHIBIT;
        if (hv) begin
            unique case (code)
                CODE_CLEAR:  op = OP_CLEAR;
                CODE_WRITE:  op = OP_WRITE;
                CODE_VERIFY: op = OP_VERIFY;
                default:     op = OP_INHIBIT;
            endcase
        end
        return op;
    endfunction

    function automatic int cnt_width(input int edges);
        return (edges > 1) ? $clog2(edges) : 1;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_prog_pkg::*;
(
    input  logic [3:0] mode_code_i,
    input  logic       hv_ok_i,
    output prog_op_e   op_o
);
    always_comb begin
        op_o = decode_op(mode_code_i, hv_ok_i);
    end
endmodule

// File: rtl/otp_addr_seq.sv
module otp_addr_seq
    import otp_prog_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int EDGES = DEF_EDGES,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = cnt_width(EDGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              xclk_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(EDGES - 1);

    logic             xclk_q;
    logic             rise;
    logic [CNT_W-1:0] edge_cnt;

    assign rise = xclk_i & ~xclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xclk_q   <= 1'b0;
            edge_cnt <= '0;
            addr_o   <= '0;
        end else begin
            xclk_q <= xclk_i;
            if (clear_i) begin
                edge_cnt <= '0;
                addr_o   <= '0;
            end else if (rise) begin
                if (edge_cnt == LAST_CNT) begin
                    edge_cnt <= '0;
                    if (addr_o != LAST_ADDR) begin
                        addr_o <= addr_o + 1'b1;
                    end
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
    import otp_prog_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  split_byte_t       wr_data_i,
    output split_byte_t       rd_data_o
);
    logic [BYTE_W-1:0] cells [DEPTH];

    // blank part: all ones; programming only clears bits
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en_i) begin
            cells[addr_i] <= cells[addr_i] & wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o <= '1;
        end else begin
            rd_data_o <= cells[addr_i];
        end
    end
endmodule

// File: rtl/otp_prog_port.sv
module otp_prog_port
    import otp_prog_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int EDGES = DEF_EDGES,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_hv_i,
    input  logic [3:0]       mode_code_i,
    input  logic             xclk_i,
    input  logic [NIB_W-1:0] data_lo_i,
    input  logic [NIB_W-1:0] data_hi_i,
    output logic [NIB_W-1:0] data_lo_o,
    output logic [NIB_W-1:0] data_hi_o,
    output logic             data_oe_o
);
    prog_op_e          op;
    logic [ADDR_W-1:0] cur_addr;
    split_byte_t       wr_byte;
    split_byte_t       rd_byte;
    split_byte_t       out_q;
    logic              oe_q;

    otp_mode_decode u_dec (
        .mode_code_i (mode_code_i),
        .hv_ok_i     (prog_hv_i),
        .op_o        (op)
    );

    otp_addr_seq #(.DEPTH(DEPTH), .EDGES(EDGES)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .clear_i (op == OP_CLEAR),
        .xclk_i  (xclk_i),
        .addr_o  (cur_addr)
    );

    assign wr_byte.lo = data_lo_i;
    assign wr_byte.hi = data_hi_i;

    otp_cell_array #(.DEPTH(DEPTH)) u_cells (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (cur_addr),
        .wr_en_i   (op == OP_WRITE),
        .wr_data_i (wr_byte),
        .rd_data_o (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 1'b0;
            out_q <= '0;
        end else begin
            oe_q  <= (op == OP_VERIFY);
            out_q <= (op == OP_VERIFY) ? rd_byte : '0;
        end
    end

    assign data_lo_o = out_q.lo;
    assign data_hi_o = out_q.hi;
    assign data_oe_o = oe_q;
endmodule

// File: rtl/otp_prog_checker.sv
module otp_prog_checker
    import otp_prog_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_hv_i,
    input logic [3:0]        mode_code_i,
    input logic [ADDR_W-1:0] addr,
    input logic              data_oe_o,
    input logic [NIB_W-1:0]  data_lo_o,
    input logic [NIB_W-1:0]  data_hi_o
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        addr <= ADDR_W'(DEPTH - 1));

    assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (rst)
        (prog_hv_i && mode_code_i == CODE_CLEAR) |=> (addr == '0));

    assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
        (seen && addr != $past(addr)) |-> ((addr - $past(addr)) == ADDR_W'(1) || addr == '0));

    assert_verify_drives_R8: assert property (@(posedge clk) disable iff (rst)
        (prog_hv_i && mode_code_i == CODE_VERIFY) |=> data_oe_o);

    assert_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
        !(prog_hv_i && mode_code_i == CODE_VERIFY) |=> !data_oe_o);

    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (rst)
        !data_oe_o |-> (data_lo_o == '0 && data_hi_o == '0));
endmodule

bind otp_prog_port otp_prog_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .prog_hv_i   (prog_hv_i),
    .mode_code_i (mode_code_i),
    .addr        (cur_addr),
    .data_oe_o   (data_oe_o),
    .data_lo_o   (data_lo_o),
    .data_hi_o   (data_hi_o)
);

// File: tb/otp_prog_port_bench.sv
module otp_prog_port_bench;
    localparam int DEPTH = 8064;
    localparam logic [3:0] C_CLR = 4'b0101, C_WR = 4'b1110, C_VF = 4'b1100,
                           C_INH = 4'b1101, C_INH2 = 4'b1111, C_UNDEF = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_hv_i = 1'b1;
    logic [3:0] mode_code_i = C_INH;
    logic xclk_i = 1'b0;
    logic [3:0] data_lo_i = '0, data_hi_i = '0;
    logic [3:0] data_lo_o, data_hi_o;
    logic data_oe_o;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [7:0] mem_m [DEPTH];
    int addr_m = 0, cnt_m = 0;

    always #4 clk = ~clk;

    otp_prog_port u_otp_prog_port (
        .clk(clk), .rst(rst), .prog_hv_i(prog_hv_i), .mode_code_i(mode_code_i),
        .xclk_i(xclk_i), .data_lo_i(data_lo_i), .data_hi_i(data_hi_i),
        .data_lo_o(data_lo_o), .data_hi_o(data_hi_o), .data_oe_o(data_oe_o)
    );

    // 0 inhibit, 1 clear, 2 write, 3 verify (R2)
    function automatic int ref_op(input logic [3:0] c, input logic hv);
        if (!hv) return 0;
        if (c == C_CLR) return 1;
        if (c == C_WR)  return 2;
        if (c == C_VF)  return 3;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] c, input logic hv);
        mode_code_i = c;
        prog_hv_i = hv;
        if (ref_op(c, hv) == 1) begin addr_m = 0; cnt_m = 0; end
        tick(1);
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            xclk_i = 1'b1; tick(1);
            xclk_i = 1'b0; tick(1);
            if (ref_op(mode_code_i, prog_hv_i) != 1) begin
                if (cnt_m == 3) begin
                    cnt_m = 0;
                    if (addr_m != DEPTH - 1) addr_m++;
                end else cnt_m++;
            end
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input logic hv);
        data_lo_i = d[3:0];
        data_hi_i = d[7:4];
        set_mode(C_WR, hv);
        tick(1);
        if (hv) mem_m[addr_m] = mem_m[addr_m] & d;
        set_mode(C_INH, 1'b1);
    endtask

    task automatic verify(input string req);
        set_mode(C_VF, 1'b1);
        tick(2);
        check(data_oe_o == 1'b1, req, int'(data_oe_o), 1);
        check({data_hi_o, data_lo_o} == mem_m[addr_m], req,
              int'({data_hi_o, data_lo_o}), int'(mem_m[addr_m]));
        set_mode(C_INH, 1'b1);
    endtask

    task automatic quiet(input logic [3:0] c, input logic hv, input string req);
        set_mode(c, hv);
        tick(2);
        check(data_oe_o == 1'b0 && data_lo_o == 4'h0 && data_hi_o == 4'h0, req,
              int'({data_oe_o, data_hi_o, data_lo_o}), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        check(data_oe_o == 1'b0, "R1", int'(data_oe_o), 0);
        verify("R1");
        // R6 / R3: distinct bytes at neighbours
        write_byte(8'hA5, 1'b1);
        verify("R6");
        pulse(3);
        verify("R3");               // still at 0
        pulse(1);
        verify("R3");               // now at 1, blank
        write_byte(8'h3C, 1'b1);
        verify("R6");
        write_byte(8'hF0, 1'b1);    // 3C & F0 = 30, no bit set
        verify("R6");
        write_byte(8'hFF, 1'b1);
        verify("R6");
        write_byte(8'h00, 1'b0);    // R7: supply absent
        verify("R7");
        // R4: clear, edges inside clear ignored, partial count reset
        set_mode(C_CLR, 1'b1);
        pulse(4);
        set_mode(C_INH, 1'b1);
        verify("R4");
        pulse(2);
        set_mode(C_CLR, 1'b1);
        set_mode(C_INH, 1'b1);
        pulse(2);
        verify("R4");
        // R9 / R2 quiet in non-verify operations
        quiet(C_INH, 1'b1, "R9");
        quiet(C_INH2, 1'b1, "R9");
        quiet(C_WR, 1'b0, "R9");
        quiet(C_CLR, 1'b1, "R9");
        quiet(C_VF, 1'b0, "R2");
        quiet(C_UNDEF, 1'b1, "R10");
        // R10: undefined code counts edges, neither writes nor clears
        set_mode(C_UNDEF, 1'b1);
        pulse(4);
        data_lo_i = 4'h0; data_hi_i = 4'h0;
        tick(2);
        set_mode(C_INH, 1'b1);
        verify("R10");
        // random mix
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = int'($urandom % 7);
            case (sel)
                0, 1: begin
                    set_mode(($urandom % 2) ? C_INH2 : C_UNDEF, 1'b1);
                    pulse(1 + int'($urandom % 5));
                    set_mode(C_INH, 1'b1);
                end
                2, 3: write_byte(8'($urandom), 1'($urandom % 4 != 0));
                4, 5: verify("R8");
                default: if ($urandom % 4 == 0) set_mode(C_CLR, 1'b1);
                         else quiet(C_WR, 1'b0, "R9");
            endcase
        end
        // R5: saturation at last location
        set_mode(C_CLR, 1'b1);
        set_mode(C_INH, 1'b1);
        pulse(4 * (DEPTH - 1));
        write_byte(8'h12, 1'b1);
        verify("R5");
        pulse(8);
        verify("R5");
        check(addr_m == DEPTH - 1, "R5", addr_m, DEPTH - 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule